// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block orders the steps of a warm or soft reset for a small system and restarts boot when they are done. Three sources can ask for a reset: an asynchronous pin (synchronised by two flops and detected on its falling edge), a one-cycle software pulse from a control register, and a one-cycle watchdog expiry pulse. A static select decides whether the pin starts a warm or a soft reset. Software and watchdog requests always start a soft reset. Power-on reset is asynchronous and overrides everything else.

Every sequence follows the same order. The block puts the affected reset domains into reset and then drives the active-low status output low. A warm sequence first floats the I/O and then waits for the pin to be released. Initialization then runs for a fixed number of cycles, after which status returns high. A soft sequence also pauses the system clocks for a short window. The sequence ends with a one-cycle boot start pulse.

The boot-mode pins are captured once, in the first clock after power-on reset, and are then held in a status register. Warm and soft resets read that register and do not sample the pins. A sticky register reports which source caused the last sequence. A request that arrives while a sequence is running waits until after the boot pulse.

Top module: `rst_seq_ctrl`

## Requirements
- R1: In a warm sequence, io_hiz is high for at least one cycle while every dom_rst bit is still low. It stays high for as long as the domains are held in reset. Soft sequences never raise io_hiz.
- R2: rst_stat_n falls only in the cycle after dom_rst has become non-zero. It rises again only after exactly INIT_CYCLES (default 16) cycles in which rst_stat_n is low and dom_rst is zero.
- R3: In a warm sequence, the hold phase (rst_stat_n low, dom_rst non-zero) lasts while the two-flop-synchronised pin is still low. A pin held low for L clock edges gives L-3 hold cycles. A soft sequence holds for 1 cycle.
- R4: A falling edge of the synchronised pin starts a warm reset when pin_soft is 0 and a soft reset when pin_soft is 1. A sw_rst_req or wdt_expire pulse starts a soft reset. last_cause shows the source of the current or last sequence: 1 = pin, 2 = software, 3 = watchdog, 0 = power-on.
- R5: dom_rst bit 0 is core logic, bit 1 is the memory/PCIe state machines, bit 2 is the memory/PCIe configuration registers and bit 3 is the clock/power control. Power-on resets 4'b1111, warm resets 4'b0111 and soft resets 4'b0011.
- R6: After a soft sequence raises rst_stat_n, clk_pause is high for exactly PAUSE_CYCLES (default 8) cycles, and boot_start pulses in the cycle after clk_pause falls. Warm and power-on sequences never raise clk_pause. clk_pause is high only while rst_stat_n is high.
- R7: boot_mode takes the value of boot_cfg in the first clock after power-on reset is released. It does not change again until the next power-on reset, whatever warm or soft resets happen.
- R8: A request that arrives during a sequence is held and served after that sequence's boot_start. When requests are pending together, the pin is served first, then software, then watchdog. Each request produces exactly one boot_start.
- R9: Driving por_n low in the middle of a sequence abandons that sequence at once and clears pending requests. Only the power-on sequence then produces a boot_start.
- R10: While por_n is low: rst_stat_n = 0, io_hiz = 1, dom_rst = all ones, clk_pause = 0, boot_start = 0 and last_cause = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst_n | input | 1 | Asynchronous reset request pin, active low |
| pin_soft | input | 1 | 1: pin requests a soft reset; 0: a warm reset |
| sw_rst_req | input | 1 | One-cycle software reset request |
| wdt_expire | input | 1 | One-cycle watchdog expiry |
| boot_cfg | input | CFG_W | Boot-mode configuration pins |
| rst_stat_n | output | 1 | Reset status, low while in reset and initializing |
| io_hiz | output | 1 | Forces module I/O to high impedance |
| clk_pause | output | 1 | Pauses the system clocks |
| dom_rst | output | NDOM | Per-domain reset, active high |
| boot_start | output | 1 | One-cycle pulse that starts boot |
| boot_mode | output | CFG_W | Stored boot-mode status |
| last_cause | output | 2 | Sticky cause of the last reset |

## Verification
The assertions assume that sw_rst_req and wdt_expire are single-cycle pulses. They also assume that pin_rst_n stays low for several cycles once it falls, so the synchroniser sees one clean edge, and that boot_cfg is steady when por_n is released. The stimulus keeps to these assumptions. It drives every pulse for exactly one clock, holds the pin low for at least six cycles, and changes boot_cfg only while power-on reset is held or long after it has been released. Power-on reset is the one input allowed to break in at any time: the checks are disabled while it is low and resume from the reset state.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_PIN  = 2'd1,
        CAUSE_SW   = 2'd2,
        CAUSE_WDT  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        K_POR  = 2'd0,
        K_WARM = 2'd1,
        K_SOFT = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_HIZ    = 3'd1,
        S_ASSERT = 3'd2,
        S_HOLD   = 3'd3,
        S_INIT   = 3'd4,
        S_PAUSE  = 3'd5,
        S_BOOT   = 3'd6
    } state_e;

    localparam int unsigned NUM_SRC = 3;

endpackage

// File: rtl/rst_in_sync.sv
module rst_in_sync (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic pin_lvl_n,
    output logic pin_fall
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.s1   = pin_n;
        sq_d.s2   = sq_q.s1;
        sq_d.prev = sq_q.s2;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sq_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        sq_q <= sq_d;
    end

    assign pin_lvl_n = sq_q.s2;
    assign pin_fall  = sq_q.prev & ~sq_q.s2;

endmodule

// File: rtl/rst_req_arb.sv
module rst_req_arb
    import rst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   pin_fall,
    input  logic   sw_req,
    input  logic   wdt_req,
    input  logic   take,
    output logic   pend_any,
    output cause_e sel
);

    logic [NUM_SRC-1:0] pend_d, pend_q;
    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] grant;

    assign raw = {wdt_req, sw_req, pin_fall};

    // lowest index wins: pin, then software, then watchdog
    always_comb begin
        grant = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) grant = NUM_SRC'(1) << i;
        end
    end

    always_comb begin
        sel = CAUSE_NONE;
        if      (grant[0]) sel = CAUSE_PIN;
        else if (grant[1]) sel = CAUSE_SW;
        else if (grant[2]) sel = CAUSE_WDT;
    end

    always_comb begin
        pend_d = pend_q;
        if (take) pend_d = pend_d & ~grant;
        pend_d = pend_d | raw;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_any = |pend_q;

    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!por_n)
        take |-> pend_any) else $error("take without pending request"); // R8

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(grant)) else $error("grant not one-hot"); // R8

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int unsigned NDOM         = 4,
    parameter int unsigned CFG_W        = 4,
    parameter int unsigned INIT_CYCLES  = 16,
    parameter int unsigned PAUSE_CYCLES = 8,
    parameter logic [NDOM-1:0] WARM_MASK = 4'b0111,
    parameter logic [NDOM-1:0] SOFT_MASK = 4'b0011
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_lvl_n,
    input  logic             pin_soft,
    input  logic [CFG_W-1:0] boot_cfg,
    input  logic             pend_any,
    input  cause_e           sel,
    output logic             take,
    output logic             rst_stat_n,
    output logic             io_hiz,
    output logic             clk_pause,
    output logic [NDOM-1:0]  dom_rst,
    output logic             boot_start,
    output logic [CFG_W-1:0] boot_mode,
    output cause_e           last_cause
);

    localparam int unsigned MAXC  = (INIT_CYCLES > PAUSE_CYCLES) ? INIT_CYCLES : PAUSE_CYCLES;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] PAUSE_LAST = CNT_W'(PAUSE_CYCLES - 1);

    typedef struct packed {
        state_e           state;
        kind_e            kind;
        logic [CNT_W-1:0] cnt;
        cause_e           cause;
        logic [CFG_W-1:0] mode;
        logic             cfg_ok;
    } seq_t;

    seq_t sq_d, sq_q;

    function automatic logic [NDOM-1:0] mask_of(kind_e k);
        case (k)
            K_WARM:  return WARM_MASK;
            K_SOFT:  return SOFT_MASK;
            default: return '1;
        endcase
    endfunction

    always_comb begin
        sq_d = sq_q;
        take = 1'b0;
        if (!sq_q.cfg_ok) begin
            sq_d.mode   = boot_cfg;
            sq_d.cfg_ok = 1'b1;
        end
        case (sq_q.state)
            S_IDLE: begin
                if (pend_any) begin
                    take       = 1'b1;
                    sq_d.cause = sel;
                    if (sel == CAUSE_PIN && !pin_soft) begin
                        sq_d.kind  = K_WARM;
                        sq_d.state = S_HIZ;
                    end else begin
                        sq_d.kind  = K_SOFT;
                        sq_d.state = S_ASSERT;
                    end
                end
            end
            S_HIZ:    sq_d.state = S_ASSERT;
            S_ASSERT: sq_d.state = S_HOLD;
            S_HOLD: begin
                if (sq_q.kind != K_WARM || pin_lvl_n) begin
                    sq_d.state = S_INIT;
                    sq_d.cnt   = '0;
                end
            end
            S_INIT: begin
                if (sq_q.cnt == INIT_LAST) begin
                    sq_d.cnt   = '0;
                    sq_d.state = (sq_q.kind == K_SOFT) ? S_PAUSE : S_BOOT;
                end else begin
                    sq_d.cnt = sq_q.cnt + 1'b1;
                end
            end
            S_PAUSE: begin
                if (sq_q.cnt == PAUSE_LAST) begin
                    sq_d.cnt   = '0;
                    sq_d.state = S_BOOT;
                end else begin
                    sq_d.cnt = sq_q.cnt + 1'b1;
                end
            end
            S_BOOT:  sq_d.state = S_IDLE;
            default: sq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sq_q.state  <= S_HOLD;
            sq_q.kind   <= K_POR;
            sq_q.cnt    <= '0;
            sq_q.cause  <= CAUSE_NONE;
            sq_q.mode   <= '0;
            sq_q.cfg_ok <= 1'b0;
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        rst_stat_n = 1'b1;
        io_hiz     = 1'b0;
        clk_pause  = 1'b0;
        dom_rst    = '0;
        boot_start = 1'b0;
        case (sq_q.state)
            S_HIZ:    io_hiz = 1'b1;
            S_ASSERT: begin
                io_hiz  = (sq_q.kind != K_SOFT);
                dom_rst = mask_of(sq_q.kind);
            end
            S_HOLD: begin
                io_hiz     = (sq_q.kind != K_SOFT);
                dom_rst    = mask_of(sq_q.kind);
                rst_stat_n = 1'b0;
            end
            S_INIT:  rst_stat_n = 1'b0;
            S_PAUSE: clk_pause  = 1'b1;
            S_BOOT:  boot_start = 1'b1;
            default: ;
        endcase
    end

    assign boot_mode  = sq_q.mode;
    assign last_cause = sq_q.cause;

    AST_HIZ_LEADS_RST: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(|dom_rst) && sq_q.kind == K_WARM) |-> $past(io_hiz)) else $error("reset before hi-z"); // R1

    AST_SOFT_NO_HIZ: assert property (@(posedge clk) disable iff (!por_n)
        (sq_q.kind == K_SOFT && sq_q.state != S_IDLE) |-> !io_hiz) else $error("hi-z on soft reset"); // R1

    AST_STAT_AFTER_DOM: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_stat_n) |-> $past(|dom_rst)) else $error("status fell early"); // R2

    AST_STAT_RISE_CLEAN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_stat_n) |-> ($past(dom_rst) == '0)) else $error("status rose during reset"); // R2

    AST_WARM_WAITS_PIN: assert property (@(posedge clk) disable iff (!por_n)
        (sq_q.state == S_HOLD && sq_q.kind == K_WARM && !pin_lvl_n) |=> !rst_stat_n) else $error("init before pin release"); // R3

    AST_SOFT_SPARES: assert property (@(posedge clk) disable iff (!por_n)
        (sq_q.kind == K_SOFT) |-> ((dom_rst & ~SOFT_MASK) == '0)) else $error("soft reset hit spared domain"); // R5

    AST_PAUSE_STAT_HIGH: assert property (@(posedge clk) disable iff (!por_n)
        clk_pause |-> rst_stat_n) else $error("pause while in reset"); // R6

    AST_BOOT_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(clk_pause) |-> boot_start) else $error("no boot after pause"); // R6

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!por_n)
        (sq_q.cfg_ok && $past(sq_q.cfg_ok)) |-> $stable(boot_mode)) else $error("boot mode changed"); // R7

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int unsigned NDOM         = 4,
    parameter int unsigned CFG_W        = 4,
    parameter int unsigned INIT_CYCLES  = 16,
    parameter int unsigned PAUSE_CYCLES = 8,
    parameter logic [NDOM-1:0] WARM_MASK = 4'b0111,
    parameter logic [NDOM-1:0] SOFT_MASK = 4'b0011
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             pin_rst_n,
    input  logic             pin_soft,
    input  logic             sw_rst_req,
    input  logic             wdt_expire,
    input  logic [CFG_W-1:0] boot_cfg,
    output logic             rst_stat_n,
    output logic             io_hiz,
    output logic             clk_pause,
    output logic [NDOM-1:0]  dom_rst,
    output logic             boot_start,
    output logic [CFG_W-1:0] boot_mode,
    output logic [1:0]       last_cause
);

    logic   pin_lvl_n;
    logic   pin_fall;
    logic   pend_any;
    logic   take;
    cause_e sel;
    cause_e cause;

    rst_in_sync u_sync (
        .clk       (clk),
        .por_n     (por_n),
        .pin_n     (pin_rst_n),
        .pin_lvl_n (pin_lvl_n),
        .pin_fall  (pin_fall)
    );

    rst_req_arb u_arb (
        .clk      (clk),
        .por_n    (por_n),
        .pin_fall (pin_fall),
        .sw_req   (sw_rst_req),
        .wdt_req  (wdt_expire),
        .take     (take),
        .pend_any (pend_any),
        .sel      (sel)
    );

    rst_seq_fsm #(
        .NDOM         (NDOM),
        .CFG_W        (CFG_W),
        .INIT_CYCLES  (INIT_CYCLES),
        .PAUSE_CYCLES (PAUSE_CYCLES),
        .WARM_MASK    (WARM_MASK),
        .SOFT_MASK    (SOFT_MASK)
    ) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .pin_lvl_n  (pin_lvl_n),
        .pin_soft   (pin_soft),
        .boot_cfg   (boot_cfg),
        .pend_any   (pend_any),
        .sel        (sel),
        .take       (take),
        .rst_stat_n (rst_stat_n),
        .io_hiz     (io_hiz),
        .clk_pause  (clk_pause),
        .dom_rst    (dom_rst),
        .boot_start (boot_start),
        .boot_mode  (boot_mode),
        .last_cause (cause)
    );

    assign last_cause = cause;

endmodule

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rst_seq_ctrl;

    localparam int NDOM = 4;
    localparam int CFG_W = 4;

    logic clk = 1'b0;
    logic por_n, pin_rst_n, pin_soft, sw_rst_req, wdt_expire;
    logic [CFG_W-1:0] boot_cfg;
    logic rst_stat_n, io_hiz, clk_pause, boot_start;
    logic [NDOM-1:0] dom_rst;
    logic [CFG_W-1:0] boot_mode;
    logic [1:0] last_cause;

    always #5 clk = ~clk;

    rst_seq_ctrl u0 (
        .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .pin_soft(pin_soft),
        .sw_rst_req(sw_rst_req), .wdt_expire(wdt_expire), .boot_cfg(boot_cfg),
        .rst_stat_n(rst_stat_n), .io_hiz(io_hiz), .clk_pause(clk_pause),
        .dom_rst(dom_rst), .boot_start(boot_start), .boot_mode(boot_mode),
        .last_cause(last_cause)
    );

    typedef struct {
        int dom;
        int init;
        int pause;
        int hiz;   // 2: hi-z before domains, 1: hi-z only with domains, 0: none
        int hold;  // -1: not checked
        int mode;
        int cause;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    int cur_mode;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic exp_t mk(int dom, int pause, int hiz, int hold, int cause);
        exp_t e;
        e.dom = dom; e.init = 16; e.pause = pause; e.hiz = hiz;
        e.hold = hold; e.mode = cur_mode; e.cause = cause;
        return e;
    endfunction

    // monitor: accumulate one sequence, compare at boot_start
    int a_dom, a_init, a_pause, a_hold, a_any_hiz, a_early_hiz;
    initial begin
        a_dom = 0; a_init = 0; a_pause = 0; a_hold = 0; a_any_hiz = 0; a_early_hiz = 0;
        forever begin
            @(negedge clk);
            if (!por_n) begin
                a_dom = 0; a_init = 0; a_pause = 0; a_hold = 0; a_any_hiz = 0; a_early_hiz = 0;
            end
            a_dom = a_dom | int'(dom_rst);
            if (!rst_stat_n && dom_rst == '0) a_init++;
            if (!rst_stat_n && dom_rst != '0) a_hold++;
            if (clk_pause) a_pause++;
            if (io_hiz) a_any_hiz = 1;
            if (io_hiz && dom_rst == '0 && rst_stat_n) a_early_hiz = 1;
            if (boot_start) begin
                if (q.size() == 0) begin
                    chk("R8 unexpected boot_start", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R5 domain mask", a_dom, e.dom);
                    chk("R2 init cycles", a_init, e.init);
                    chk("R6 pause cycles", a_pause, e.pause);
                    chk("R1 hi-z ordering", a_early_hiz ? 2 : a_any_hiz, e.hiz);
                    if (e.hold >= 0) chk("R3 hold cycles", a_hold, e.hold);
                    chk("R7 boot mode", int'(boot_mode), e.mode);
                    chk("R4 R8 cause", int'(last_cause), e.cause);
                end
                a_dom = 0; a_init = 0; a_pause = 0; a_hold = 0; a_any_hiz = 0; a_early_hiz = 0;
            end
        end
    end

    task automatic pulse_sw();
        sw_rst_req = 1'b1; @(negedge clk); sw_rst_req = 1'b0;
    endtask

    task automatic pulse_wdt();
        wdt_expire = 1'b1; @(negedge clk); wdt_expire = 1'b0;
    endtask

    task automatic pin_low(int len);
        pin_rst_n = 1'b0;
        repeat (len) @(negedge clk);
        pin_rst_n = 1'b1;
    endtask

    task automatic wait_done();
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, queue=%0d expected=0", q.size());
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        por_n = 1'b0; pin_rst_n = 1'b1; pin_soft = 1'b0;
        sw_rst_req = 1'b0; wdt_expire = 1'b0; boot_cfg = 4'h5;
        repeat (3) @(negedge clk);
        // R10: state during power-on reset
        chk("R10 rst_stat_n", int'(rst_stat_n), 0);
        chk("R10 io_hiz", int'(io_hiz), 1);
        chk("R10 dom_rst", int'(dom_rst), 15);
        chk("R10 clk_pause", int'(clk_pause), 0);
        chk("R10 boot_start", int'(boot_start), 0);
        chk("R10 last_cause", int'(last_cause), 0);
        cur_mode = 5;
        q.push_back(mk(15, 0, 1, -1, 0));
        por_n = 1'b1;
        wait_done();

        // R7: pins change, stored mode must stay
        boot_cfg = 4'hA;
        q.push_back(mk(3, 8, 0, 1, 2));
        pulse_sw();
        wait_done();
        chk("R7 mode after soft", int'(boot_mode), 5);

        q.push_back(mk(3, 8, 0, 1, 3));
        pulse_wdt();
        wait_done();

        // R3: warm via pin held 20 edges -> 17 hold cycles
        q.push_back(mk(7, 0, 2, 17, 1));
        pin_low(20);
        wait_done();
        chk("R7 mode after warm", int'(boot_mode), 5);

        // R4: pin as soft source
        pin_soft = 1'b1;
        q.push_back(mk(3, 8, 0, 1, 1));
        pin_low(6);
        wait_done();
        pin_soft = 1'b0;

        // R8: simultaneous sw and wdt -> sw first
        q.push_back(mk(3, 8, 0, 1, 2));
        q.push_back(mk(3, 8, 0, 1, 3));
        sw_rst_req = 1'b1; wdt_expire = 1'b1;
        @(negedge clk);
        sw_rst_req = 1'b0; wdt_expire = 1'b0;
        wait_done();

        // R8: wdt during a running soft sequence
        q.push_back(mk(3, 8, 0, 1, 2));
        q.push_back(mk(3, 8, 0, 1, 3));
        pulse_sw();
        repeat (10) @(negedge clk);
        pulse_wdt();
        wait_done();

        // R8: sw during warm hold phase
        q.push_back(mk(7, 0, 2, 17, 1));
        q.push_back(mk(3, 8, 0, 1, 2));
        pin_rst_n = 1'b0;
        repeat (8) @(negedge clk);
        pulse_sw();
        repeat (11) @(negedge clk);
        pin_rst_n = 1'b1;
        wait_done();

        // R9: power-on in the middle of a soft sequence, wdt pending
        pulse_sw();
        repeat (8) @(negedge clk);
        pulse_wdt();
        @(negedge clk);
        boot_cfg = 4'h3;
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 R10 dom_rst during por", int'(dom_rst), 15);
        chk("R9 last_cause cleared", int'(last_cause), 0);
        cur_mode = 3;
        q.push_back(mk(15, 0, 1, -1, 0));
        por_n = 1'b1;
        wait_done();
        repeat (40) @(negedge clk);
        chk("R9 no stale boot", q.size(), 0);
        chk("R7 mode relatched by por", int'(boot_mode), 3);

        q.push_back(mk(3, 8, 0, 1, 2));
        pulse_sw();
        wait_done();
        chk("R8 all sequences booted", q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule